// File: doc/BRIEF.md
# Dual-Stack 32-bit Stack Processor Core

This core executes one 16-bit instruction per clock from an instruction port. It keeps the top of its 32-bit data stack in a register. The other data-stack entries, and all of the return stack, live in two small RAM arrays, each with a wrapping up/down pointer. Each instruction falls into one of five classes: literal push, unconditional jump, conditional jump, subroutine call, or an ALU/stack operation. An ALU/stack instruction carries separate fields for the operation, the data-stack and return-stack pointer deltas, two copy enables and a return flag. One instruction can therefore compute a value, reshape both stacks and return from a subroutine.

A data-memory port and an IO port share one byte address bus and one write-data bus. Each port has its own read and write strobes. Every fetch and every store takes two consecutive instructions. The first instruction drives the strobe. The second collects the read data, or removes the stored value from the stack. Read data is expected one clock after the read strobe, so a plain synchronous RAM can serve the memory port directly.

Top module: `stack_cpu`

## Requirements
- R1: An instruction with bit 15 set is a literal. Bits 14:0, zero-extended to 32 bits, become the new top of stack and the old top moves one place down.
- R2: While reset is high, and in the first cycle after it drops, the instruction address is 0 and all four access strobes are low.
- R3: When bits 15:13 are 000, the instruction jumps: the next instruction address becomes bits 12:0.
- R4: When bits 15:13 are 001, the instruction pops the top of the data stack. It jumps to bits 12:0 only if every bit of the popped value is zero; otherwise execution continues at the next address.
- R5: When bits 15:13 are 010, the instruction pushes the address of the next instruction onto the return stack and jumps to bits 12:0. An ALU instruction with its return flag set pops the return stack and continues at the popped address, in the same cycle as its own operation.
- R6: When bits 15:13 are 011, the instruction is an ALU instruction. Its fields are: op in bits 12:8, return flag in bit 7, copy-top-to-second in bit 6, copy-top-to-return in bit 5, return delta in bits 3:2, and data delta in bits 1:0. Each delta is 2-bit two's complement: 01 means +1 and 11 means -1. These fields make up dup, drop, swap, over and nip; op 0 passes the top and op 9 selects the second entry.
- R7: Binary ops combine the second entry N with the top T. The op codes are: 1 for N+T, 2 for xor, 3 for and, 4 for or, 6 for equality, 7 for signed N<T and 8 for unsigned N<T. Op 5 inverts T. Comparisons give all ones for true and zero for false.
- R8: Op 11 shifts N right (logical) by T, and op 12 shifts N left by T. A shift amount of 32 or more gives zero.
- R9: Op 10 selects the return-stack top. Combined with the R6 fields, this gives three operations: move to the return stack, copy from it, and pop from it.
- R10: The return stack keeps 32 entries. The data stack keeps 32 entries below its top register. Filling either stack to that depth and then unloading it returns every value in last-in, first-out order.
- R11: Op 13 reads memory: it drives the mem_rd strobe with bus_addr set to the low bits of T, and leaves the stack unchanged. Addresses count bytes and words sit at multiples of four. The next instruction, op 14, loads mem_rdata into T.
- R12: Op 17 writes memory: it drives the mem_wr strobe with bus_addr set to T and bus_wdata set to N, then pops the address (data delta -1). The following drop completes the store, leaving the entries that were below the value.
- R13: Ops 15 and 16 read from IO, and op 18 writes to IO. They follow the same two-instruction sequence as R11 and R12, but use io_rd, io_wr and io_rdata instead of the memory signals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iaddr | output | 13 | Instruction word address |
| idata | input | 16 | Instruction at iaddr, same cycle |
| bus_addr | output | DADDR_W | Byte address for memory and IO |
| bus_wdata | output | DATA_W | Write data for memory and IO |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | DATA_W | Memory read data, one cycle after mem_rd |
| io_rd | output | 1 | IO read strobe |
| io_wr | output | 1 | IO write strobe |
| io_rdata | input | DATA_W | IO read data, one cycle after io_rd |

## Verification
The ALU operation and the subroutine return can fall in the same cycle. So can a data-stack pop and a return-stack push. Test programs call a subroutine whose only instruction is an add with the return flag set, and a nested caller whose final instruction is an invert with the return flag set. The outcome is judged by the value the caller stores after the call comes back: it is correct only if the operation saw the right operands and control resumed at the right place. The move-to-return and pop-from-return sequences, including a full 32-deep round trip, are judged in the same way through the stored values.

// File: rtl/stack_cpu_pkg.sv
package stack_cpu_pkg;

    localparam int unsigned INSN_W = 16;
    localparam int unsigned PC_W   = 13;
    localparam int unsigned IMM_W  = 15;

    typedef enum logic [1:0] {
        CL_JMP  = 2'd0,
        CL_CBR  = 2'd1,
        CL_CALL = 2'd2,
        CL_ALU  = 2'd3
    } insn_class_e;

    typedef enum logic [4:0] {
        OP_T      = 5'd0,
        OP_ADD    = 5'd1,
        OP_XOR    = 5'd2,
        OP_AND    = 5'd3,
        OP_OR     = 5'd4,
        OP_INV    = 5'd5,
        OP_EQ     = 5'd6,
        OP_LTS    = 5'd7,
        OP_LTU    = 5'd8,
        OP_N      = 5'd9,
        OP_R      = 5'd10,
        OP_SHR    = 5'd11,
        OP_SHL    = 5'd12,
        OP_MRD    = 5'd13,
        OP_MDONE  = 5'd14,
        OP_IORD   = 5'd15,
        OP_IODONE = 5'd16,
        OP_MWR    = 5'd17,
        OP_IOWR   = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic              is_lit;
        insn_class_e       cls;
        logic [IMM_W-1:0]  imm;
        logic [PC_W-1:0]   target;
        alu_op_e           op;
        logic              ret;
        logic              t2n;
        logic              t2r;
        logic              spare;
        logic [1:0]        rdelta;
        logic [1:0]        ddelta;
    } insn_t;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } bus_req_t;

    function automatic insn_t decode_insn(input logic [INSN_W-1:0] w);
        insn_t d;
        d.is_lit = w[15];
        d.cls    = insn_class_e'(w[14:13]);
        d.imm    = w[14:0];
        d.target = w[12:0];
        d.op     = alu_op_e'(w[12:8]);
        d.ret    = w[7];
        d.t2n    = w[6];
        d.t2r    = w[5];
        d.spare  = w[4];
        d.rdelta = w[3:2];
        d.ddelta = w[1:0];
        return d;
    endfunction

    function automatic bus_req_t op_bus_req(input alu_op_e op);
        bus_req_t r;
        r = '0;
        case (op)
            OP_MRD:  r.mem_rd = 1'b1;
            OP_MWR:  r.mem_wr = 1'b1;
            OP_IORD: r.io_rd  = 1'b1;
            OP_IOWR: r.io_wr  = 1'b1;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/stack_cpu_stack.sv
module stack_cpu_stack #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       delta,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] top
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] cells [DEPTH];
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] step;
    logic [PTR_W-1:0] ptr_n;

    assign step  = {{(PTR_W-2){delta[1]}}, delta};
    assign ptr_n = ptr + step;
    assign top   = cells[ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            ptr <= ptr_n;
            if (wr_en) begin
                cells[ptr_n] <= wr_data;
            end
        end
    end

    // R10
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (delta == 2'b00) |=> (ptr == $past(ptr)));

endmodule

// File: rtl/stack_cpu_alu.sv
module stack_cpu_alu
    import stack_cpu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] tos,
    input  logic [DATA_W-1:0] nos,
    input  logic [DATA_W-1:0] rtop,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    output logic [DATA_W-1:0] result
);
    localparam int unsigned SH_W = $clog2(DATA_W);

    logic              too_far;
    logic [SH_W-1:0]   amount;
    logic [DATA_W-1:0] shr_v;
    logic [DATA_W-1:0] shl_v;

    assign too_far = |tos[DATA_W-1:SH_W];
    assign amount  = tos[SH_W-1:0];
    assign shr_v   = too_far ? '0 : (nos >> amount);
    assign shl_v   = too_far ? '0 : (nos << amount);

    always_comb begin
        case (op)
            OP_T:      result = tos;
            OP_ADD:    result = nos + tos;
            OP_XOR:    result = nos ^ tos;
            OP_AND:    result = nos & tos;
            OP_OR:     result = nos | tos;
            OP_INV:    result = ~tos;
            OP_EQ:     result = {DATA_W{nos == tos}};
            OP_LTS:    result = {DATA_W{$signed(nos) < $signed(tos)}};
            OP_LTU:    result = {DATA_W{nos < tos}};
            OP_N:      result = nos;
            OP_R:      result = rtop;
            OP_SHR:    result = shr_v;
            OP_SHL:    result = shl_v;
            OP_MRD:    result = tos;
            OP_MDONE:  result = mem_rdata;
            OP_IORD:   result = tos;
            OP_IODONE: result = io_rdata;
            OP_MWR:    result = nos;
            OP_IOWR:   result = nos;
            default:   result = tos;
        endcase
    end

    // R8
    shift_range_chk: assert final (!(too_far && (op == OP_SHL || op == OP_SHR)) || result == '0);

endmodule

// File: rtl/stack_cpu.sv
module stack_cpu
    import stack_cpu_pkg::*;
#(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned DSTACK_DEPTH = 32,
    parameter int unsigned RSTACK_DEPTH = 32,
    parameter int unsigned DADDR_W      = 16
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PC_W-1:0]    iaddr,
    input  logic [INSN_W-1:0]  idata,
    output logic [DADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic               mem_rd,
    output logic               mem_wr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               io_rd,
    output logic               io_wr,
    input  logic [DATA_W-1:0]  io_rdata
);
    localparam int unsigned LIT_PAD = DATA_W - IMM_W;
    localparam int unsigned PC_PAD  = DATA_W - PC_W;

    logic [PC_W-1:0]   pc, pc_n, pc_inc;
    logic [DATA_W-1:0] tos, tos_n;
    logic [DATA_W-1:0] nos, rtop, alu_res, r_wdata;
    logic [1:0]        d_delta, r_delta;
    logic              d_we, r_we;
    insn_t             dec;
    bus_req_t          req;
    logic              is_lit, is_jmp, is_cbr, is_call, is_alu;

    assign dec     = decode_insn(idata);
    assign is_lit  = dec.is_lit;
    assign is_jmp  = !dec.is_lit && dec.cls == CL_JMP;
    assign is_cbr  = !dec.is_lit && dec.cls == CL_CBR;
    assign is_call = !dec.is_lit && dec.cls == CL_CALL;
    assign is_alu  = !dec.is_lit && dec.cls == CL_ALU;
    assign pc_inc  = pc + 1'b1;

    stack_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op        (dec.op),
        .tos       (tos),
        .nos       (nos),
        .rtop      (rtop),
        .mem_rdata (mem_rdata),
        .io_rdata  (io_rdata),
        .result    (alu_res)
    );

    stack_cpu_stack #(.WIDTH(DATA_W), .DEPTH(DSTACK_DEPTH)) u_dstack (
        .clk     (clk),
        .rst     (rst),
        .delta   (d_delta),
        .wr_en   (d_we),
        .wr_data (tos),
        .top     (nos)
    );

    stack_cpu_stack #(.WIDTH(DATA_W), .DEPTH(RSTACK_DEPTH)) u_rstack (
        .clk     (clk),
        .rst     (rst),
        .delta   (r_delta),
        .wr_en   (r_we),
        .wr_data (r_wdata),
        .top     (rtop)
    );

    always_comb begin
        pc_n    = pc_inc;
        tos_n   = tos;
        d_delta = 2'b00;
        d_we    = 1'b0;
        r_delta = 2'b00;
        r_we    = 1'b0;
        r_wdata = tos;
        if (is_lit) begin
            tos_n   = {{LIT_PAD{1'b0}}, dec.imm};
            d_delta = 2'b01;
            d_we    = 1'b1;
        end else begin
            case (dec.cls)
                CL_JMP: pc_n = dec.target;
                CL_CBR: begin
                    tos_n   = nos;
                    d_delta = 2'b11;
                    if (tos == '0) pc_n = dec.target;
                end
                CL_CALL: begin
                    r_delta = 2'b01;
                    r_we    = 1'b1;
                    r_wdata = {{PC_PAD{1'b0}}, pc_inc};
                    pc_n    = dec.target;
                end
                default: begin
                    tos_n   = alu_res;
                    d_delta = dec.ddelta;
                    d_we    = dec.t2n;
                    r_delta = dec.rdelta;
                    r_we    = dec.t2r;
                    if (dec.ret) pc_n = rtop[PC_W-1:0];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            tos <= '0;
        end else begin
            pc  <= pc_n;
            tos <= tos_n;
        end
    end

    assign req       = (is_alu && !rst) ? op_bus_req(dec.op) : '0;
    assign mem_rd    = req.mem_rd;
    assign mem_wr    = req.mem_wr;
    assign io_rd     = req.io_rd;
    assign io_wr     = req.io_wr;
    assign bus_addr  = tos[DADDR_W-1:0];
    assign bus_wdata = nos;
    assign iaddr     = pc;

    // R2
    reset_vector_chk: assert property (@(posedge clk)
        $past(rst) |-> (iaddr == '0));

    // R1
    literal_push_chk: assert property (@(posedge clk) disable iff (rst)
        is_lit |=> (tos == {{LIT_PAD{1'b0}}, $past(dec.imm)}) && (nos == $past(tos)));

    // R3
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        is_jmp |=> (iaddr == $past(dec.target)));

    // R4
    cbr_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (is_cbr && tos == '0) |=> (iaddr == $past(dec.target)) && (tos == $past(nos)));

    // R4
    cbr_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (is_cbr && tos != '0) |=> (iaddr == $past(pc) + 1'b1));

    // R5
    call_link_chk: assert property (@(posedge clk) disable iff (rst)
        is_call |=> (rtop[PC_W-1:0] == $past(pc) + 1'b1) && (iaddr == $past(dec.target)));

    // R5
    return_chk: assert property (@(posedge clk) disable iff (rst)
        (is_alu && dec.ret) |=> (iaddr == $past(rtop[PC_W-1:0])));

    // R11
    mem_complete_chk: assert property (@(posedge clk) disable iff (rst)
        (is_alu && dec.op == OP_MDONE) |=> (tos == $past(mem_rdata)));

    // R13
    io_complete_chk: assert property (@(posedge clk) disable iff (rst)
        (is_alu && dec.op == OP_IODONE) |=> (tos == $past(io_rdata)));

endmodule

// File: tb/stack_cpu_test.sv
`timescale 1ns/1ps
module stack_cpu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] iaddr;
    logic [15:0] idata;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        mem_rd, mem_wr, io_rd, io_wr;
    logic [31:0] mem_rdata = '0;
    logic [31:0] io_rdata  = '0;

    logic [15:0] rom  [1024];
    logic [31:0] dmem [256];
    logic [31:0] io_regs [4];
    logic [31:0] exp_mem [256];
    bit          exp_vld [256];
    string       exp_tag [256];

    int checks = 0;
    int fails  = 0;
    int pe     = 0;
    int next_slot = 128;
    int src_next  = 0;
    int halt_pc;
    logic [31:0] io_wr_expect;

    always #2 clk = ~clk;

    stack_cpu uut (
        .clk(clk), .rst(rst), .iaddr(iaddr), .idata(idata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
        .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata)
    );

    assign idata = rom[iaddr[9:0]];

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= dmem[bus_addr[9:2]];
        if (mem_wr) dmem[bus_addr[9:2]] <= bus_wdata;
        if (io_rd)  io_rdata  <= io_regs[bus_addr[3:2]];
        if (io_wr)  io_regs[bus_addr[3:2]] <= bus_wdata;
    end

    // ---- encoders ----
    function automatic logic [15:0] e_alu(input logic [4:0] op, input logic ret,
        input logic t2n, input logic t2r, input logic [1:0] rd, input logic [1:0] dd);
        return {3'b011, op, ret, t2n, t2r, 1'b0, rd, dd};
    endfunction

    localparam logic [15:0] I_DUP   = {3'b011, 5'd0,  4'b0100, 2'b00, 2'b01};
    localparam logic [15:0] I_DROP  = {3'b011, 5'd9,  4'b0000, 2'b00, 2'b11};
    localparam logic [15:0] I_SWAP  = {3'b011, 5'd9,  4'b0100, 2'b00, 2'b00};
    localparam logic [15:0] I_OVER  = {3'b011, 5'd9,  4'b0100, 2'b00, 2'b01};
    localparam logic [15:0] I_NIP   = {3'b011, 5'd0,  4'b0000, 2'b00, 2'b11};
    localparam logic [15:0] I_TOR   = {3'b011, 5'd9,  4'b0010, 2'b01, 2'b11};
    localparam logic [15:0] I_RAT   = {3'b011, 5'd10, 4'b0100, 2'b00, 2'b01};
    localparam logic [15:0] I_RFROM = {3'b011, 5'd10, 4'b0100, 2'b11, 2'b01};
    localparam logic [15:0] I_MRD   = {3'b011, 5'd13, 4'b0000, 2'b00, 2'b00};
    localparam logic [15:0] I_MDONE = {3'b011, 5'd14, 4'b0000, 2'b00, 2'b00};
    localparam logic [15:0] I_IORD  = {3'b011, 5'd15, 4'b0000, 2'b00, 2'b00};
    localparam logic [15:0] I_IODN  = {3'b011, 5'd16, 4'b0000, 2'b00, 2'b00};
    localparam logic [15:0] I_MWR   = {3'b011, 5'd17, 4'b0000, 2'b00, 2'b11};
    localparam logic [15:0] I_IOWR  = {3'b011, 5'd18, 4'b0000, 2'b00, 2'b11};
    localparam int SUB_ADD = 900;
    localparam int SUB_OUT = 920;

    task automatic emit(input logic [15:0] w);
        rom[pe] = w;
        pe++;
    endtask

    task automatic lit(input int v);
        emit({1'b1, v[14:0]});
    endtask

    task automatic binop(input int op);
        emit(e_alu(op[4:0], 1'b0, 1'b0, 1'b0, 2'b00, 2'b11));
    endtask

    // push a fresh random source word, return its value
    task automatic load_rand(output logic [31:0] v);
        int s;
        s = src_next;
        src_next++;
        v = $urandom;
        dmem[s] = v;
        lit(s * 4); emit(I_MRD); emit(I_MDONE);
    endtask

    task automatic load_val(input logic [31:0] v);
        int s;
        s = src_next;
        src_next++;
        dmem[s] = v;
        lit(s * 4); emit(I_MRD); emit(I_MDONE);
    endtask

    task automatic store_exp(input logic [31:0] v, input string tag);
        int s;
        s = next_slot;
        next_slot++;
        exp_mem[s] = v; exp_vld[s] = 1'b1; exp_tag[s] = tag;
        lit(s * 4); emit(I_MWR); emit(I_DROP);
    endtask

    // four words that must be skipped
    task automatic bad_block(input string tag);
        int s;
        s = next_slot;
        next_slot++;
        exp_mem[s] = 32'h0; exp_vld[s] = 1'b1; exp_tag[s] = tag;
        lit(16'h0BAD); lit(s * 4); emit(I_MWR); emit(I_DROP);
    endtask

    function automatic logic [31:0] model(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            1:  return a + b;
            2:  return a ^ b;
            3:  return a & b;
            4:  return a | b;
            6:  return (a == b) ? 32'hFFFF_FFFF : 32'h0;
            7:  return ($signed(a) < $signed(b)) ? 32'hFFFF_FFFF : 32'h0;
            8:  return (a < b) ? 32'hFFFF_FFFF : 32'h0;
            11: return (b >= 32) ? 32'h0 : (a >> b[4:0]);
            12: return (b >= 32) ? 32'h0 : (a << b[4:0]);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic build_program();
        logic [31:0] x, y, a, b;
        int p;
        int ops [10] = '{1, 2, 3, 4, 6, 7, 8, 11, 12, 5};
        // R1 zero extension of literal
        lit(15'h7FFF); store_exp(32'h0000_7FFF, "R1 literal max");
        lit(0);        store_exp(32'h0, "R1 literal zero");
        // R6 stack words
        load_rand(x); load_rand(y); emit(I_SWAP);
        store_exp(x, "R6 swap top"); store_exp(y, "R6 swap second");
        load_rand(x); load_rand(y); emit(I_OVER);
        store_exp(x, "R6 over top"); store_exp(y, "R6 over mid"); store_exp(x, "R6 over low");
        lit(16'h1234); load_rand(x); load_rand(y); emit(I_NIP);
        store_exp(y, "R6 nip top"); store_exp(32'h1234, "R6 nip below");
        load_rand(x); emit(I_DUP);
        store_exp(x, "R6 dup a"); store_exp(x, "R6 dup b");
        lit(16'h2345); load_rand(x); emit(I_DROP);
        store_exp(32'h2345, "R6 drop");
        // R9 return stack transfers
        load_rand(x); load_rand(y); emit(I_TOR); emit(I_RAT);
        store_exp(y, "R9 copy from return");
        emit(I_RFROM);
        store_exp(y, "R9 pop from return"); store_exp(x, "R9 under");
        // R5 call with ALU+return, nested
        load_rand(a); load_rand(b); emit({3'b010, 13'(SUB_ADD)});
        store_exp(a + b, "R5 add with return");
        load_rand(a); load_rand(b); emit({3'b010, 13'(SUB_OUT)});
        store_exp(~(a + b), "R5 nested return");
        // R3 jump over a block
        p = pe; emit({3'b000, 13'(p + 5)}); bad_block("R3 skipped block");
        lit(16'h3131); store_exp(32'h3131, "R3 after jump");
        // R4 taken: pops zero, keeps marker
        lit(16'h4141); lit(0); p = pe; emit({3'b001, 13'(p + 5)});
        bad_block("R4 taken skip");
        store_exp(32'h4141, "R4 taken pop");
        // R4 not taken
        lit(16'h4242); lit(7); p = pe; emit({3'b001, 13'(p + 5)});
        lit(16'h0022);
        begin
            int s;
            s = next_slot; next_slot++;
            exp_mem[s] = 32'h22; exp_vld[s] = 1'b1; exp_tag[s] = "R4 fall through";
            lit(s * 4); emit(I_MWR); emit(I_DROP);
        end
        store_exp(32'h4242, "R4 fall pop");
        // R12 store pops both
        lit(16'h5151); load_rand(x);
        store_exp(x, "R12 stored value"); store_exp(32'h5151, "R12 stack after store");
        // R13 IO read and write
        lit(4); emit(I_IORD); emit(I_IODN); store_exp(32'hCAFE_1234, "R13 io read");
        load_rand(x); io_wr_expect = x; lit(8); emit(I_IOWR); emit(I_DROP);
        // R11 address with low bits set still hits the word
        load_val(32'h0BEE_F00D); emit(I_DROP);
        lit((src_next - 1) * 4 + 3); emit(I_MRD); emit(I_MDONE);
        store_exp(32'h0BEE_F00D, "R11 byte offset");
        // R7 / R8 random
        for (int k = 0; k < 24; k++) begin
            int op;
            op = ops[$urandom % 10];
            if (op == 5) begin
                load_rand(a);
                emit(e_alu(5'd5, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00));
                store_exp(~a, "R7 invert");
            end else begin
                load_rand(a);
                if (op == 11 || op == 12) b = 32'($urandom % 40);
                else if (op == 6 && k % 2 == 0) b = a;
                else b = $urandom;
                load_val(b);
                binop(op);
                store_exp(model(op, a, b), (op == 11 || op == 12) ? "R8 shift" : "R7 alu");
            end
        end
        // R8 directed edges
        load_rand(a); lit(32); binop(12); store_exp(32'h0, "R8 shl 32");
        load_rand(a); lit(33); binop(11); store_exp(32'h0, "R8 shr 33");
        load_rand(a); lit(31); binop(11); store_exp(a >> 31, "R8 shr 31");
        load_rand(a); lit(0);  binop(12); store_exp(a, "R8 shl 0");
        // R10 depth 32 on both stacks
        for (int i = 0; i < 32; i++) lit(i * 3 + 1);
        for (int i = 0; i < 32; i++) emit(I_TOR);
        for (int i = 0; i < 32; i++) emit(I_RFROM);
        for (int i = 31; i >= 0; i--) store_exp(32'(i * 3 + 1), "R10 depth");
        halt_pc = pe;
        emit({3'b000, 13'(pe)});
        // subroutines
        rom[SUB_ADD]     = e_alu(5'd1, 1'b1, 1'b0, 1'b0, 2'b11, 2'b11);
        rom[SUB_OUT]     = {3'b010, 13'(SUB_ADD)};
        rom[SUB_OUT + 1] = e_alu(5'd5, 1'b1, 1'b0, 1'b0, 2'b11, 2'b00);
    endtask

    initial begin
        #200000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        for (int i = 0; i < 1024; i++) rom[i] = 16'h6000;
        for (int i = 0; i < 256; i++) begin
            dmem[i] = '0; exp_mem[i] = '0; exp_vld[i] = 1'b0; exp_tag[i] = "";
        end
        io_regs[0] = '0; io_regs[1] = 32'hCAFE_1234; io_regs[2] = '0; io_regs[3] = '0;
        build_program();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2 reset state
        check("R2 iaddr in reset", {19'd0, iaddr}, 32'h0);
        check("R2 strobes in reset", {28'd0, mem_rd, mem_wr, io_rd, io_wr}, 32'h0);
        rst = 1'b0;
        check("R2 first fetch", {19'd0, iaddr}, 32'h0);
        repeat (3000) @(posedge clk);
        @(negedge clk);
        check("R3 reached halt", {19'd0, iaddr}, 32'(halt_pc));
        check("R13 io write", io_regs[2], io_wr_expect);
        for (int s = 0; s < 256; s++) begin
            if (exp_vld[s]) check(exp_tag[s], dmem[s], exp_mem[s]);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule